// File: doc/BRIEF.md
# Core-Local Interrupt Arbiter

This block collects a parameterised set of interrupt lines next to a small processor core and reduces them to a single request. Each line owns a pending flag, an enable flag, a trigger mode (level, or edge with a chosen polarity), a dispatch mode (vectored or through a shared entry) and an 8-bit control byte. A global setting decides how many upper bits of that control byte form the level; the bits below form the priority. Among the sources that are both pending and enabled, the block picks a winner and forwards it to the core only when its level is strictly above a global threshold.

Together with the request, the core receives the winning ID, its level, its dispatch flag and the address to jump to: an entry of a vector table for vectored sources, or a shared handler address for the rest. When the core takes an interrupt it pulses a claim input, which clears the pending flag of an edge-triggered winner. Software configures everything through a word-addressed register port with a single-cycle write strobe and a combinational read path.

Top module: `clic_arbiter`

## Requirements
- R1: After a synchronous reset, irq_valid, irq_id, irq_level, irq_shv and irq_addr are 0, the level-width field reads 4, the threshold, table base and shared entry read 0, and every source word reads 0.
- R2: Input line i is the source with ID i (ID 3 software, ID 7 timer, 19 and up external, at most 4096 sources); word 1 is read-only and returns the source count in bits [15:0] and version 0x01 in bits [23:16].
- R3: In edge mode (source word bit 2 set) the pending flag (bit 0) sets on a rising edge of the line, or on a falling edge when bit 3 is set; a register write to the source word then loads bit 0 into the pending flag.
- R4: In level mode (bit 2 clear) the pending flag copies the line each cycle and register writes to bit 0 have no effect.
- R5: Word 0 bits [3:0] give the level width n (values above 8 act as 8); the level is the control byte (source word bits [15:8]) shifted right by 8-n, and a winner is presented only when its level is strictly greater than the threshold in word 2 bits [7:0].
- R6: Among enabled (bit 1) pending sources the winner has the highest level, then the highest priority, then the highest ID.
- R7: For a vectored winner (bit 4 set) irq_addr is the table base (word 3) plus 4 times the ID; otherwise it is the shared entry (word 4) with bit 0 cleared when word 4 bit 0 is 1, and the table base when word 4 bit 0 is 0; irq_shv shows bit 4 of the winner.
- R8: A claim pulse while irq_valid is high clears the pending flag of the edge-triggered source named by irq_id; a selected edge in the same cycle keeps it set; a claim while irq_valid is low, or for a level source, changes nothing.
- R9: Clearing the enable bit removes a source from arbitration while its pending flag is kept.
- R10: The request outputs are registered: they reflect register or pending state one clock after that state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC | Interrupt lines, bit i is source ID i |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address (0 level width, 1 info, 2 threshold, 3 table base, 4 shared entry, 16+ID source word) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| claim | input | 1 | Core takes the presented interrupt |
| irq_valid | output | 1 | Request to the core |
| irq_id | output | ID_W | Winning source ID |
| irq_level | output | 8 | Level of the winner |
| irq_shv | output | 1 | Winner is vectored |
| irq_addr | output | 32 | Handler address |

## Verification
The claim that clears an edge-triggered pending flag and a fresh selected edge on the same line can land on the same clock edge. The bench raises the line of the presented source in the very cycle it pulses claim, then checks that the request stays up with the same ID and that the source word still reads pending; a design that lets the claim win loses that interrupt and is reported.

// File: rtl/clic_pkg.sv
package clic_pkg;

    localparam int CTL_W   = 8;
    localparam int VERSION = 1;

    // word addresses of the global registers and the first source word
    localparam int A_CFG   = 0;
    localparam int A_INFO  = 1;
    localparam int A_THR   = 2;
    localparam int A_BASE  = 3;
    localparam int A_ENTRY = 4;
    localparam int A_SRC0  = 16;

    typedef struct packed {
        logic vec;
        logic fall;
        logic edge_trig;
    } attr_t;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        attr_t            attr;
        logic             en;
    } src_cfg_t;

    // level = upper nl bits of the control byte, as a number
    function automatic logic [CTL_W-1:0] lvl_of(logic [CTL_W-1:0] ctl, logic [3:0] nl);
        if (nl == 4'd0)
            return '0;
        else if (nl >= 4'd8)
            return ctl;
        else
            return ctl >> (4'd8 - nl);
    endfunction

    function automatic logic [31:0] vec_addr(logic [31:0] base, logic [11:0] id);
        return base + {18'd0, id, 2'b00};
    endfunction

endpackage

// File: rtl/clic_src_cell.sv
module clic_src_cell
    import clic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line,
    input  attr_t attr,
    input  logic  sw_wr,
    input  logic  sw_val,
    input  logic  claim_clr,
    output logic  pend
);
    logic line_q;
    logic hit;

    assign hit = attr.fall ? (line_q & ~line) : (line & ~line_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            line_q <= line;
            if (!attr.edge_trig)
                pend <= line;
            else if (hit)
                pend <= 1'b1;
            else if (sw_wr)
                pend <= sw_val;
            else if (claim_clr)
                pend <= 1'b0;
        end
    end
endmodule

// File: rtl/clic_pick.sv
module clic_pick
    import clic_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int ID_W    = 5
) (
    input  logic [NUM_SRC-1:0]            act,
    input  logic [NUM_SRC-1:0][CTL_W-1:0] ctl,
    output logic                          found,
    output logic [ID_W-1:0]               win_id,
    output logic [CTL_W-1:0]              win_ctl
);
    // ascending scan with >= : equal control bytes resolve to the higher ID;
    // comparing whole control bytes orders by level first, then priority
    always_comb begin
        found   = 1'b0;
        win_id  = '0;
        win_ctl = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (act[i] && (!found || ctl[i] >= win_ctl)) begin
                found   = 1'b1;
                win_id  = ID_W'(i);
                win_ctl = ctl[i];
            end
        end
    end
endmodule

// File: rtl/clic_arbiter.sv
module clic_arbiter
    import clic_pkg::*;
#(
    parameter int NUM_SRC = 24,
    parameter int ADDR_W  = 16,
    localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               claim,
    output logic               irq_valid,
    output logic [ID_W-1:0]    irq_id,
    output logic [CTL_W-1:0]   irq_level,
    output logic               irq_shv,
    output logic [31:0]        irq_addr
);
    initial begin
        if (NUM_SRC < 1 || NUM_SRC > 4096)
            $error("NUM_SRC out of range");
    end

    logic [3:0]       nlbits_q;
    logic [CTL_W-1:0] thr_q;
    logic [31:0]      base_q;
    logic [31:0]      entry_q;
    src_cfg_t         cfg_q [NUM_SRC];

    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0]            act;
    logic [NUM_SRC-1:0]            vec_v;
    logic [NUM_SRC-1:0][CTL_W-1:0] ctl_v;

    logic             found;
    logic [ID_W-1:0]  win_id;
    logic [CTL_W-1:0] win_ctl;
    logic [CTL_W-1:0] win_lvl;
    logic             win_vec;

    // global registers
    always_ff @(posedge clk) begin
        if (rst) begin
            nlbits_q <= 4'd4;
            thr_q    <= '0;
            base_q   <= '0;
            entry_q  <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_CFG))   nlbits_q <= reg_wdata[3:0];
            if (reg_addr == ADDR_W'(A_THR))   thr_q    <= reg_wdata[CTL_W-1:0];
            if (reg_addr == ADDR_W'(A_BASE))  base_q   <= reg_wdata;
            if (reg_addr == ADDR_W'(A_ENTRY)) entry_q  <= reg_wdata;
        end
    end

    // per-source state
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic sel;
        assign sel = reg_wr && (reg_addr == ADDR_W'(A_SRC0 + i));

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= '0;
            else if (sel)
                cfg_q[i] <= '{ctl:  reg_wdata[15:8],
                              attr: '{vec: reg_wdata[4], fall: reg_wdata[3],
                                      edge_trig: reg_wdata[2]},
                              en:   reg_wdata[1]};
        end

        clic_src_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .line      (src_irq[i]),
            .attr      (cfg_q[i].attr),
            .sw_wr     (sel),
            .sw_val    (reg_wdata[0]),
            .claim_clr (claim && irq_valid && (irq_id == ID_W'(i))),
            .pend      (pend[i])
        );

        assign act[i]   = pend[i] & cfg_q[i].en;
        assign vec_v[i] = cfg_q[i].attr.vec;
        assign ctl_v[i] = cfg_q[i].ctl;
    end

    clic_pick #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_pick (
        .act     (act),
        .ctl     (ctl_v),
        .found   (found),
        .win_id  (win_id),
        .win_ctl (win_ctl)
    );

    assign win_lvl = lvl_of(win_ctl, nlbits_q);
    assign win_vec = vec_v[win_id];

    // registered request to the core
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_id    <= '0;
            irq_level <= '0;
            irq_shv   <= 1'b0;
            irq_addr  <= '0;
        end else begin
            irq_valid <= found && (win_lvl > thr_q);
            irq_id    <= win_id;
            irq_level <= win_lvl;
            irq_shv   <= win_vec;
            if (win_vec)
                irq_addr <= vec_addr(base_q, 12'(win_id));
            else if (entry_q[0])
                irq_addr <= {entry_q[31:1], 1'b0};
            else
                irq_addr <= base_q;
        end
    end

    // read path
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(A_CFG))   reg_rdata = {28'd0, nlbits_q};
        if (reg_addr == ADDR_W'(A_INFO))  reg_rdata = {8'd0, 8'(VERSION), 16'(NUM_SRC)};
        if (reg_addr == ADDR_W'(A_THR))   reg_rdata = {24'd0, thr_q};
        if (reg_addr == ADDR_W'(A_BASE))  reg_rdata = base_q;
        if (reg_addr == ADDR_W'(A_ENTRY)) reg_rdata = entry_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_addr == ADDR_W'(A_SRC0 + i))
                reg_rdata = {16'd0, cfg_q[i].ctl, 3'd0, cfg_q[i].attr.vec,
                             cfg_q[i].attr.fall, cfg_q[i].attr.edge_trig,
                             cfg_q[i].en, pend[i]};
        end
    end
endmodule

// File: rtl/clic_arbiter_chk.sv
module clic_arbiter_chk #(
    parameter int NUM_SRC = 24,
    parameter int ID_W    = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_valid,
    input logic [ID_W-1:0]    irq_id,
    input logic [7:0]         irq_level,
    input logic               irq_shv,
    input logic [31:0]        irq_addr,
    input logic [7:0]         thr,
    input logic [31:0]        base,
    input logic [NUM_SRC-1:0] act,
    input logic [NUM_SRC-1:0] vec_bits
);
    logic [NUM_SRC-1:0] act_prev;
    logic [NUM_SRC-1:0] vec_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_prev <= '0;
            vec_prev <= '0;
        end else begin
            act_prev <= act;
            vec_prev <= vec_bits;
        end
    end

    // R5: presented level strictly above the threshold of the previous cycle
    p_thresh_gate_r5: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_level > $past(thr)));

    // R6 / R9: presented source was pending and enabled one cycle earlier
    p_winner_active_r6: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> act_prev[irq_id]);

    // R7: dispatch flag matches the winner's attribute
    p_shv_match_r7: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_shv == vec_prev[irq_id]));

    // R7: vectored address lands in the table slot of the ID
    p_vec_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_shv) |-> (irq_addr == $past(base) + (32'(irq_id) << 2)));
endmodule

bind clic_arbiter clic_arbiter_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .irq_valid (irq_valid),
    .irq_id    (irq_id),
    .irq_level (irq_level),
    .irq_shv   (irq_shv),
    .irq_addr  (irq_addr),
    .thr       (thr_q),
    .base      (base_q),
    .act       (act),
    .vec_bits  (vec_v)
);

// File: tb/clic_arbiter_tb_top.sv
module clic_arbiter_tb_top;
    localparam int N  = 24;
    localparam int AW = 16;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_irq = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          claim = 1'b0;
    logic          irq_valid;
    logic [IW-1:0] irq_id;
    logic [7:0]    irq_level;
    logic          irq_shv;
    logic [31:0]   irq_addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    clic_arbiter #(.NUM_SRC(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .src_irq(src_irq), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .claim(claim), .irq_valid(irq_valid), .irq_id(irq_id),
        .irq_level(irq_level), .irq_shv(irq_shv), .irq_addr(irq_addr)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [31:0] sw(bit p, bit en, bit edg, bit fall, bit vec, logic [7:0] ctl);
        return {16'd0, ctl, 3'd0, vec, fall, edg, en, p};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = AW'(a);
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_claim();
        @(negedge clk); claim = 1'b1;
        @(negedge clk); claim = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; src_irq = '0; claim = 1'b0; reg_wr = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    // edge source with pending set via two writes (mode first, then flag)
    task automatic edge_pend(int id, bit en, bit vec, logic [7:0] ctl);
        wr(16 + id, sw(0, en, 1, 0, vec, ctl));
        wr(16 + id, sw(1, en, 1, 0, vec, ctl));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        chk("R1 valid", irq_valid, 0);
        chk("R1 id", irq_id, 0);
        chk("R1 level", irq_level, 0);
        chk("R1 addr", irq_addr, 0);
        rd(0, d); chk("R1 level width", d, 4);
        rd(2, d); chk("R1 threshold", d, 0);
        rd(4, d); chk("R1 entry", d, 0);
        rd(16 + 7, d); chk("R1 source word", d, 0);
        rd(1, d); chk("R2 info", d, 32'h0001_0018);
    endtask

    task automatic t_level();
        logic [31:0] d;
        do_reset();
        wr(16 + 7, sw(0, 1, 0, 0, 0, 8'h10));
        @(negedge clk); src_irq[7] = 1'b1;
        tick();
        chk("R10 not yet", irq_valid, 0);
        tick();
        chk("R2 timer id", {irq_valid, 3'b0, irq_id}, {1'b1, 3'b0, 5'd7});
        chk("R5 level", irq_level, 1);
        // R9: disable keeps pending
        wr(16 + 7, sw(0, 0, 0, 0, 0, 8'h10));
        tick();
        chk("R9 disabled drops", irq_valid, 0);
        rd(16 + 7, d); chk("R9 pending kept", d[0], 1);
        wr(16 + 7, sw(0, 1, 0, 0, 0, 8'h10));
        tick();
        chk("R9 re-enabled", irq_valid, 1);
        @(negedge clk); src_irq[7] = 1'b0;
        tick(); tick();
        chk("R4 follows low", irq_valid, 0);
        wr(16 + 7, sw(1, 1, 0, 0, 0, 8'h10));
        rd(16 + 7, d); chk("R4 write ignored", d[0], 0);
        tick();
        chk("R4 no request", irq_valid, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        do_reset();
        wr(16 + 3, sw(0, 1, 1, 0, 0, 8'h20));
        @(negedge clk); src_irq[3] = 1'b1;
        @(negedge clk); src_irq[3] = 1'b0;
        tick();
        chk("R3 rising sets", {irq_valid, 3'b0, irq_id}, {1'b1, 3'b0, 5'd3});
        chk("R5 level 2", irq_level, 2);
        tick();
        chk("R3 held after line low", irq_valid, 1);
        pulse_claim();
        tick();
        chk("R8 claim clears", irq_valid, 0);
        rd(16 + 3, d); chk("R8 pending cleared", d[0], 0);
        wr(16 + 3, sw(1, 1, 1, 0, 0, 8'h20));
        chk("R10 one cycle later", irq_valid, 0);
        tick();
        chk("R3 sw set", irq_valid, 1);
        wr(16 + 3, sw(0, 1, 1, 0, 0, 8'h20));
        tick();
        chk("R3 sw clear", irq_valid, 0);
        // falling polarity
        wr(16 + 5, sw(0, 1, 1, 1, 0, 8'h10));
        @(negedge clk); src_irq[5] = 1'b1;
        tick(); tick();
        chk("R3 rise ignored when falling", irq_valid, 0);
        @(negedge clk); src_irq[5] = 1'b0;
        tick(); tick();
        chk("R3 falling sets", {irq_valid, 3'b0, irq_id}, {1'b1, 3'b0, 5'd5});
    endtask

    task automatic t_thresh();
        do_reset();
        wr(16 + 7, sw(0, 1, 0, 0, 0, 8'h10));
        @(negedge clk); src_irq[7] = 1'b1;
        wr(2, 1);
        tick(); tick();
        chk("R5 equal blocked", irq_valid, 0);
        edge_pend(3, 1, 0, 8'h20);
        tick();
        chk("R5 above passes", {irq_valid, 3'b0, irq_id}, {1'b1, 3'b0, 5'd3});
        wr(2, 2);
        tick();
        chk("R5 strict", irq_valid, 0);
        wr(0, 8);
        tick();
        chk("R5 width 8 level", {irq_valid, irq_level}, {1'b1, 8'h20});
        wr(0, 0);
        wr(2, 0);
        tick();
        chk("R5 width 0 blocks", irq_valid, 0);
        wr(0, 4'hF);
        tick();
        chk("R5 width clamp", irq_level, 8'h20);
        @(negedge clk); src_irq[7] = 1'b0;
    endtask

    task automatic t_arb();
        do_reset();
        edge_pend(3, 1, 0, 8'h20);
        edge_pend(7, 1, 0, 8'h21);
        tick();
        chk("R6 priority", irq_id, 7);
        edge_pend(9, 1, 0, 8'h21);
        tick();
        chk("R6 id tie", irq_id, 9);
        edge_pend(12, 1, 0, 8'h30);
        tick();
        chk("R6 level over priority", irq_id, 12);
        edge_pend(10, 1, 0, 8'h31);
        tick();
        chk("R6 priority within level", irq_id, 10);
        chk("R6 level 3", irq_level, 3);
        wr(16 + 10, sw(1, 0, 1, 0, 0, 8'h31));
        tick();
        chk("R9 disabled skipped", irq_id, 12);
    endtask

    task automatic t_vec();
        do_reset();
        wr(3, 32'h8000_0000);
        edge_pend(7, 1, 1, 8'h10);
        tick();
        chk("R7 vector slot", irq_addr, 32'h8000_001C);
        chk("R7 shv", irq_shv, 1);
        wr(4, 32'h8000_0365);
        wr(16 + 7, sw(1, 1, 1, 0, 0, 8'h10));
        tick();
        chk("R7 shared entry", irq_addr, 32'h8000_0364);
        chk("R7 shv clear", irq_shv, 0);
        wr(4, 32'h8000_0364);
        tick();
        chk("R7 entry unselected", irq_addr, 32'h8000_0000);
    endtask

    task automatic t_claim();
        logic [31:0] d;
        do_reset();
        edge_pend(3, 0, 0, 8'h40);
        pulse_claim();
        rd(16 + 3, d); chk("R8 idle claim ignored", d[0], 1);
        wr(16 + 7, sw(0, 1, 0, 0, 0, 8'h30));
        @(negedge clk); src_irq[7] = 1'b1;
        tick(); tick();
        chk("R8 level winner", irq_id, 7);
        pulse_claim();
        tick();
        chk("R8 level not cleared", {irq_valid, 3'b0, irq_id}, {1'b1, 3'b0, 5'd7});
        wr(16 + 3, sw(1, 1, 1, 0, 0, 8'h40));
        tick();
        chk("R8 edge winner", irq_id, 3);
        // claim and new rising edge together
        @(negedge clk); claim = 1'b1; src_irq[3] = 1'b1;
        @(negedge clk); claim = 1'b0; src_irq[3] = 1'b0;
        tick();
        chk("R8 edge beats claim", {irq_valid, 3'b0, irq_id}, {1'b1, 3'b0, 5'd3});
        rd(16 + 3, d); chk("R8 pending retained", d[0], 1);
        pulse_claim();
        tick();
        chk("R8 claim then next", irq_id, 7);
        @(negedge clk); src_irq[7] = 1'b0;
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_thresh();
        t_arb();
        t_vec();
        t_claim();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule